// File: doc/BRIEF.md
# Character LCD 4-bit Write Sequencer

This block drives a character display controller that is wired for a 4-bit data path. Its output is one 8-bit word that carries an enable strobe, a register-select line and a data nibble. Each byte goes out as two nibbles, high half first. Every nibble is presented in three timed phases: enable low, enable high, enable low again. The controller latches the nibble while the strobe is high, and the two low phases give it setup and hold time.

After reset the block runs a fixed start-up program on its own, with no input needed. It first sends one nibble that switches the controller to the 4-bit path. It then sends a command that selects two lines and a 5x8 font, and a command that turns the display on with a blinking cursor. After that it accepts bytes over a valid/ready handshake. A flag on each byte tells the block whether the byte is a command or a character code. Each phase lasts `PHASE_CYCLES` clock cycles.

Top module: `lcd_nibble_writer`

## Requirements
- R1: The output word is {strobe in bit 7, register-select in bit 6, zero in bits 5:4, nibble in bits 3:0}. While idle the whole word is 0x00.
- R2: Each nibble is shown for three phases of exactly PHASE_CYCLES cycles each. The strobe is low in the first phase, high in the second and low in the third. Bits 6:0 stay unchanged across all three phases.
- R3: A byte is sent as its bits 7:4 first and then its bits 3:0.
- R4: Register-select is 0 when in_is_data is 0 (command) and 1 when in_is_data is 1 (character code).
- R5: After reset the block sends, with register-select 0, the single nibble 0x2, then 0x28 as nibbles 0x2 and 0x8, then 0x0F as nibbles 0x0 and 0xF. That is 15 phases. in_ready stays low during this sequence and goes high in the first cycle after it.
- R6: A byte is accepted in a cycle where in_valid and in_ready are both high. in_ready is low from the next cycle until the byte's sixth phase has ended, and it is high again in the cycle after that.
- R7: While rst_n is low, and for two clock edges after it is released, in_ready is 0 and the output holds the first start-up phase, 0x02.
- R8: in_valid and in_byte have no effect while in_ready is low. The byte in progress completes unchanged, and no further byte follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block can take a byte this cycle |
| in_byte | input | 8 | Byte to send |
| in_is_data | input | 1 | 1 = character code, 0 = command |
| lcd_out | output | 8 | {strobe, register-select, 2'b00, nibble} |

## Verification
A wrong phase or nibble index shows up on lcd_out within one phase. It appears as a strobe pulse that is too long or too short, as nibbles in the wrong order, or as a missing or extra pulse. A wrong top-level state shows up at in_ready. Either the byte is accepted too early, during start-up or a transfer, or in_ready stays low after the sixth phase. Comparing every cycle of every phase against the expected word exposes any of these faults within one cycle of where they start.

// File: rtl/lcd4_pkg.sv
package lcd4_pkg;
  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_IDLE = 2'd1,
    ST_SEND = 2'd2
  } seq_state_t;

  localparam int BOOT_NIBBLES = 5;
  localparam int BYTE_NIBBLES = 2;
  localparam int PHASES_PER_NIBBLE = 3;

  // start-up program: mode switch nibble, then 0x28, then 0x0F
  function automatic logic [3:0] boot_nibble(input logic [2:0] idx);
    logic [3:0] n;
    case (idx)
      3'd0:    n = 4'h2;
      3'd1:    n = 4'h2;
      3'd2:    n = 4'h8;
      3'd3:    n = 4'h0;
      3'd4:    n = 4'hF;
      default: n = 4'h0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic last
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign last = run && (cnt_q == LAST_VAL);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (last) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (cnt_q == '0));
endmodule

// File: rtl/lcd_step_counter.sv
module lcd_step_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       tick,
  input  logic [2:0] nib_count,
  output logic [1:0] phase,
  output logic [2:0] nib_idx,
  output logic       done
);
  logic [1:0] phase_q, phase_d;
  logic [2:0] nib_q, nib_d;
  logic       last_phase, last_nib;

  assign last_phase = (phase_q == 2'd2);
  assign last_nib   = (nib_q == nib_count - 3'd1);
  assign done       = tick && last_phase && last_nib;
  assign phase      = phase_q;
  assign nib_idx    = nib_q;

  always_comb begin
    phase_d = phase_q;
    nib_d   = nib_q;
    if (restart) begin
      phase_d = 2'd0;
      nib_d   = 3'd0;
    end else if (tick) begin
      if (last_phase) begin
        phase_d = 2'd0;
        nib_d   = last_nib ? 3'd0 : nib_q + 3'd1;
      end else begin
        phase_d = phase_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 2'd0;
      nib_q   <= 3'd0;
    end else begin
      phase_q <= phase_d;
      nib_q   <= nib_d;
    end
  end

  // R2
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && phase_q != 2'd2) |=> (phase_q == $past(phase_q) + 2'd1));
endmodule

// File: rtl/lcd_nibble_writer.sv
module lcd_nibble_writer #(
  parameter int PHASE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  input  logic       in_is_data,
  output logic [7:0] lcd_out
);
  import lcd4_pkg::*;

  logic       rst_s1_q, rst_s2_q, rst_i;
  seq_state_t state_q, state_d;
  logic [7:0] byte_q;
  logic       rs_q;
  logic       accept, run, tick, done;
  logic [1:0] phase;
  logic [2:0] nib_idx, nib_count;
  logic [3:0] nibble;
  logic       rs_cur;

  // reset released synchronously
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_i = rst_s2_q;

  assign in_ready  = (state_q == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign run       = (state_q != ST_IDLE);
  assign nib_count = (state_q == ST_BOOT) ? 3'(BOOT_NIBBLES) : 3'(BYTE_NIBBLES);

  lcd_phase_timer #(.CYCLES(PHASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_i), .run(run), .restart(accept), .last(tick)
  );

  lcd_step_counter u_steps (
    .clk(clk), .rst_n(rst_i), .restart(accept), .tick(tick),
    .nib_count(nib_count), .phase(phase), .nib_idx(nib_idx), .done(done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_BOOT: if (done)   state_d = ST_IDLE;
      ST_IDLE: if (accept) state_d = ST_SEND;
      ST_SEND: if (done)   state_d = ST_IDLE;
      default:             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) state_q <= ST_BOOT;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      byte_q <= 8'h00;
      rs_q   <= 1'b0;
    end else if (accept) begin
      byte_q <= in_byte;
      rs_q   <= in_is_data;
    end
  end

  always_comb begin
    if (state_q == ST_BOOT) begin
      nibble = boot_nibble(nib_idx);
      rs_cur = 1'b0;
    end else begin
      nibble = (nib_idx == 3'd0) ? byte_q[7:4] : byte_q[3:0];
      rs_cur = rs_q;
    end
  end

  assign lcd_out = (state_q == ST_IDLE) ? 8'h00
                 : {(phase == 2'd1), rs_cur, 2'b00, nibble};

  // R2
  strobe_setup_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(lcd_out[7]) |-> (lcd_out[6:0] == $past(lcd_out[6:0])));
  // R2
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(lcd_out[7]) |-> (lcd_out[6:0] == $past(lcd_out[6:0])));
  // R3
  upper_first_chk: assert property (@(posedge clk) disable iff (!rst_i)
    accept |=> (lcd_out[3:0] == $past(in_byte[7:4]) && lcd_out[6] == $past(in_is_data)
                && !lcd_out[7]));
  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_i)
    accept |=> !in_ready);
endmodule

// File: tb/lcd_nibble_writer_test.sv
module lcd_nibble_writer_test;
  localparam int P = 4;

  logic       clk, rst_n, in_valid, in_is_data, in_ready;
  logic [7:0] in_byte, lcd_out;
  int checks = 0;
  int errors = 0;

  // {is_data, byte, expected strobe-high word for upper, for lower}
  localparam int NV = 6;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h48, 8'hC4, 8'hC8},
    {1'b1, 8'h69, 8'hC6, 8'hC9},
    {1'b0, 8'h01, 8'h80, 8'h81},
    {1'b1, 8'hFF, 8'hCF, 8'hCF},
    {1'b1, 8'h00, 8'hC0, 8'hC0},
    {1'b0, 8'h80, 8'h88, 8'h80}
  };

  lcd_nibble_writer #(.PHASE_CYCLES(P)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_is_data(in_is_data), .lcd_out(lcd_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input logic ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // samples 3*P cycles starting now; ends on the first negedge after the nibble
  task automatic check_nibble(input logic [7:0] hi_word, input string tag);
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < P; c++) begin
        logic [7:0] e;
        e = (p == 1) ? hi_word : (hi_word & 8'h7F);
        check(lcd_out == e, tag, lcd_out, e);
        check(in_ready == 1'b0, {tag, " R6 ready low"}, {7'd0, in_ready}, 8'h00);
        @(negedge clk);
      end
    end
  endtask

  task automatic check_idle(input string tag);
    check(in_ready == 1'b1, {tag, " R6 ready"}, {7'd0, in_ready}, 8'h01);
    check(lcd_out == 8'h00, {tag, " R1 idle word"}, lcd_out, 8'h00);
  endtask

  task automatic boot_check();
    // R7: two synchroniser edges keep the first phase
    check(lcd_out == 8'h02 && !in_ready, "R7 post-release", lcd_out, 8'h02);
    @(negedge clk);
    check(lcd_out == 8'h02 && !in_ready, "R7 post-release", lcd_out, 8'h02);
    @(negedge clk);
    // R5: start-up program
    check_nibble(8'h82, "R5 mode nibble");
    check_nibble(8'h82, "R5 0x28 hi");
    check_nibble(8'h88, "R5 0x28 lo");
    check_nibble(8'h80, "R5 0x0F hi");
    check_nibble(8'h8F, "R5 0x0F lo");
    check_idle("R5 boot done");
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; in_is_data = 1'b0;
    repeat (3) @(negedge clk);
    // R7 reset state
    check(lcd_out == 8'h02, "R7 reset word", lcd_out, 8'h02);
    check(in_ready == 1'b0, "R7 reset ready", {7'd0, in_ready}, 8'h00);
    rst_n = 1'b1;
    boot_check();

    // R1 R3 R4 R6: table walk, back to back
    for (int v = 0; v < NV; v++) begin
      in_valid = 1'b1; in_is_data = VEC[v][24]; in_byte = VEC[v][23:16];
      @(negedge clk);
      in_valid = 1'b0;
      check_nibble(VEC[v][15:8], "R3 R4 upper nibble");
      check_nibble(VEC[v][7:0],  "R3 R4 lower nibble");
      check_idle("R6 after byte");
    end

    // R8: valid held with other data during a transfer
    in_valid = 1'b1; in_is_data = 1'b0; in_byte = 8'h0F;
    @(negedge clk);
    in_is_data = 1'b1; in_byte = 8'hA5;
    check_nibble(8'h80, "R8 upper unchanged");
    in_valid = 1'b0;
    check_nibble(8'h8F, "R8 lower unchanged");
    for (int k = 0; k < 4; k++) begin
      check_idle("R8 no extra byte");
      @(negedge clk);
    end

    // R7: reset in the middle of a transfer restarts start-up
    in_valid = 1'b1; in_is_data = 1'b1; in_byte = 8'h33;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (P + 1) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(lcd_out == 8'h02, "R7 mid reset word", lcd_out, 8'h02);
    check(in_ready == 1'b0, "R7 mid reset ready", {7'd0, in_ready}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    boot_check();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule